// File: doc/BRIEF.md
# Vector Configuration and Length Unit

This unit keeps the configuration state of a 32-register vector unit. A configuration command carries up to four groups. Each group is a register count plus an element type: a width of 8 to 128 bits and a signed, unsigned or floating-point tag. The groups take consecutive register indices from zero upward. The unit records the type of every covered register, and any register beyond the covered range becomes inaccessible. From the configuration it derives a maximum vector length: the total register storage divided by the summed element widths, rounded down to a power of two.

A set-length command asks for a number of elements. The unit grants the smaller of that request and the maximum length, holds the grant as the current vector length, and returns the same value one cycle later for a scalar destination register. After every accepted configuration, the unit walks through the covered registers and issues one zeroing request per cycle so that the register file can clear them. A configuration whose counts exceed the register file, or that names an unknown type, is refused with an error pulse and changes nothing.

Top module: `vcfg_unit`

## Requirements
- R1: After reset no register is configured. `maxvl` and `vl` are 0, `zero_valid` is low, and every access raises `acc_illegal`.
- R2: Group g reads its count from `cfg_cnt[6g+5:6g]` and its type from `cfg_type[5g+4:5g]`. A type is {repr[1:0], wcode[2:0]}. wcode 0..4 stands for 8, 16, 32, 64 and 128 bits, and repr 0, 1 and 2 stand for signed, unsigned and float. Groups take consecutive indices from 0 in group order. After acceptance, an access to a covered register returns its type on `acc_type` in the same cycle.
- R3: An access with `acc_idx` at or above the configured register count sets `acc_illegal` in the same cycle, and `acc_type` reads 0.
- R4: From the cycle after an accepted configuration, `maxvl` is the largest power of two not above 8192 / S, where S is the sum over groups of count times element width. `maxvl` is 1 if S exceeds 8192 and 0 if no register is configured.
- R5: A configuration whose counts sum to more than 32 is rejected, and so is one in which a group with a nonzero count has wcode above 4 or repr 3. On rejection `cfg_err` pulses in the next cycle, and the types, the count, `maxvl`, `vl` and the zeroing state are kept.
- R6: An accepted configuration of n registers makes `zero_valid` high for n consecutive cycles from the next cycle on, with `zero_idx` running 0 to n-1 in ascending order. For n = 0 there are no requests.
- R7: A set-length command sets `vl` to min(`maxvl`, `setvl_req`). In the next cycle `rd_valid` is high and `rd_data` carries the same value.
- R8: An accepted configuration clears `vl` to 0. A set-length command in the same cycle loses: `vl` stays 0, and its response returns 0.
- R9: A set-length command in the same cycle as a rejected configuration is clamped against the previous `maxvl`.
- R10: A group with count 0 is ignored, including its type field, even when that type is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_cnt | input | 24 | Four 6-bit register counts |
| cfg_type | input | 20 | Four 5-bit element types |
| cfg_err | output | 1 | Rejected-configuration pulse |
| setvl_valid | input | 1 | Set-length command strobe |
| setvl_req | input | 32 | Requested element count |
| rd_valid | output | 1 | Granted-length response strobe |
| rd_data | output | 32 | Granted length for the scalar destination |
| vl | output | 11 | Current vector length |
| maxvl | output | 11 | Current maximum vector length |
| acc_valid | input | 1 | Register access probe |
| acc_idx | input | 5 | Register index being accessed |
| acc_illegal | output | 1 | Access to an unconfigured register |
| acc_type | output | 5 | Type of the accessed register |
| zero_valid | output | 1 | Zeroing request strobe |
| zero_idx | output | 5 | Register to zero |

## Verification
A configuration command and a set-length command can fall in the same cycle, and the outcome depends on whether the configuration is accepted. The bench issues the two together, both with legal configurations and with configurations that are rejected for overflow or for a bad type. For an accepted configuration it expects a zero response and `vl` at 0. For a rejected one it expects the grant clamped to the old `maxvl`. The expected values come from a bench model of the clamp, the refusal rules and the power-of-two length rule.

// File: rtl/vcfg_unit.sv
module vcfg_unit #(
  parameter int NREG       = 32,
  parameter int NGRP       = 4,
  parameter int TOTAL_BITS = 8192,
  parameter int XLEN       = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_valid,
  input  logic [NGRP*$clog2(NREG+1)-1:0]      cfg_cnt,
  input  logic [NGRP*5-1:0]                   cfg_type,
  output logic                                cfg_err,
  input  logic                                setvl_valid,
  input  logic [XLEN-1:0]                     setvl_req,
  output logic                                rd_valid,
  output logic [XLEN-1:0]                     rd_data,
  output logic [$clog2(TOTAL_BITS/8):0]       vl,
  output logic [$clog2(TOTAL_BITS/8):0]       maxvl,
  input  logic                                acc_valid,
  input  logic [$clog2(NREG)-1:0]             acc_idx,
  output logic                                acc_illegal,
  output logic [4:0]                          acc_type,
  output logic                                zero_valid,
  output logic [$clog2(NREG)-1:0]             zero_idx
);
  localparam int IW   = $clog2(NREG);
  localparam int CW   = $clog2(NREG + 1);
  localparam int SW   = CW + $clog2(NGRP);
  localparam int KMAX = $clog2(TOTAL_BITS / 8);
  localparam int VLW  = KMAX + 1;

  logic [4:0]     type_q [NREG];
  logic [CW-1:0]  nconf_q, zn_q;
  logic [SW-1:0]  bound [NGRP];
  logic [SW-1:0]  total;
  logic [31:0]    wsum;
  logic           bad_type, cfg_ok;
  logic [VLW-1:0] maxvl_d, grant;
  logic           zact_q;
  logic [IW-1:0]  zidx_q;

  always_comb begin
    total    = '0;
    wsum     = '0;
    bad_type = 1'b0;
    for (int g = 0; g < NGRP; g++) begin
      total    = total + SW'(cfg_cnt[g*CW +: CW]);
      bound[g] = total;
      if (cfg_cnt[g*CW +: CW] != '0) begin
        if (cfg_type[g*5 +: 3] > 3'd4 || cfg_type[g*5+3 +: 2] == 2'd3) bad_type = 1'b1;
        wsum = wsum + (32'(cfg_cnt[g*CW +: CW]) << (32'(cfg_type[g*5 +: 3]) + 32'd3));
      end
    end
  end

  assign cfg_ok = cfg_valid && !bad_type && (32'(total) <= NREG);

  always_comb begin
    maxvl_d = (wsum == '0) ? '0 : VLW'(1);
    for (int k = 1; k <= KMAX; k++)
      if (wsum != '0 && (wsum << k) <= 32'(TOTAL_BITS)) maxvl_d = VLW'(1) << k;
  end

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [4:0] tnext;
      always_comb begin
        tnext = '0;
        for (int g = NGRP - 1; g >= 0; g--)
          if (SW'(i) < bound[g]) tnext = cfg_type[g*5 +: 5];
      end
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)      type_q[i] <= '0;
        else if (cfg_ok) type_q[i] <= tnext;
    end
  endgenerate

  assign grant = (setvl_req > XLEN'(maxvl)) ? maxvl : setvl_req[VLW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nconf_q  <= '0;
      maxvl    <= '0;
      vl       <= '0;
      cfg_err  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      zact_q   <= 1'b0;
      zidx_q   <= '0;
      zn_q     <= '0;
    end else begin
      cfg_err  <= cfg_valid && !cfg_ok;
      rd_valid <= setvl_valid;
      if (setvl_valid) rd_data <= cfg_ok ? '0 : XLEN'(grant);
      if (cfg_ok) begin
        nconf_q <= CW'(total);
        maxvl   <= maxvl_d;
        vl      <= '0;
        zact_q  <= (total != '0);
        zidx_q  <= '0;
        zn_q    <= CW'(total);
      end else begin
        if (setvl_valid) vl <= grant;
        if (zact_q) begin
          if (CW'(zidx_q) + CW'(1) == zn_q) zact_q <= 1'b0;
          else                              zidx_q <= zidx_q + IW'(1);
        end
      end
    end
  end

  assign zero_valid  = zact_q;
  assign zero_idx    = zidx_q;
  assign acc_illegal = acc_valid && (CW'(acc_idx) >= nconf_q);
  assign acc_type    = (acc_valid && !acc_illegal) ? type_q[acc_idx] : 5'd0;

  AST_VL_BOUND:     assert property (@(posedge clk) disable iff (!rst_n) vl <= maxvl); // R7
  AST_RD_ECHO:      assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> rd_data == XLEN'(vl)); // R7
  AST_MAXVL_POW2:   assert property (@(posedge clk) disable iff (!rst_n) $countones(maxvl) <= 1); // R4
  AST_REJECT_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) cfg_err |-> $stable(maxvl) && $stable(nconf_q)); // R5
  AST_ZERO_RANGE:   assert property (@(posedge clk) disable iff (!rst_n) zero_valid |-> CW'(zero_idx) < nconf_q); // R6
  AST_CFG_CLEAR_VL: assert property (@(posedge clk) disable iff (!rst_n) (zero_valid && zero_idx == '0) |-> vl == '0); // R8
endmodule

// File: tb/sim_vcfg_unit.sv
module sim_vcfg_unit;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        cfg_valid = 0, setvl_valid = 0, acc_valid = 0;
  logic [23:0] cfg_cnt = 0;
  logic [19:0] cfg_type = 0;
  logic [31:0] setvl_req = 0;
  logic [4:0]  acc_idx = 0;
  logic        cfg_err, rd_valid, acc_illegal, zero_valid;
  logic [31:0] rd_data;
  logic [10:0] vl, maxvl;
  logic [4:0]  acc_type, zero_idx;

  vcfg_unit u0 (.clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_cnt(cfg_cnt),
    .cfg_type(cfg_type), .cfg_err(cfg_err), .setvl_valid(setvl_valid), .setvl_req(setvl_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .vl(vl), .maxvl(maxvl), .acc_valid(acc_valid),
    .acc_idx(acc_idx), .acc_illegal(acc_illegal), .acc_type(acc_type),
    .zero_valid(zero_valid), .zero_idx(zero_idx));

  int checks = 0, fails = 0;
  bit finished = 0;
  int m_n = 0, m_maxvl = 0, m_vl = 0;
  logic [4:0] m_type [32];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_maxvl(input int s);
    int q, p;
    if (s == 0) return 0;
    q = 8192 / s;
    if (q == 0) return 1;
    p = 1;
    while (p * 2 <= q) p = p * 2;
    return p;
  endfunction

  task automatic check_access(input string tag);
    for (int i = 0; i < 32; i++) begin
      acc_valid = 1; acc_idx = 5'(i);
      #1;
      if (i >= m_n) begin
        chk(acc_illegal === 1'b1, {tag, " R3 illegal"}, int'(acc_illegal), 1);
        chk(acc_type === 5'd0, {tag, " R3 type"}, int'(acc_type), 0);
      end else begin
        chk(acc_illegal === 1'b0, {tag, " R2 legal"}, int'(acc_illegal), 0);
        chk(acc_type === m_type[i], {tag, " R2 type"}, int'(acc_type), int'(m_type[i]));
      end
    end
    acc_valid = 0;
  endtask

  task automatic do_cmd(input bit cv, input int cnt[4], input logic [4:0] ty[4],
                        input bit sv, input int req, input string tag);
    int tot = 0, s = 0, nz = 0;
    bit bad = 0, ok;
    int exp_rd = 0;
    for (int g = 0; g < 4; g++) begin
      tot += cnt[g];
      if (cnt[g] != 0) begin
        if (ty[g][2:0] > 4 || ty[g][4:3] == 3) bad = 1;
        else s += cnt[g] * (8 << ty[g][2:0]);
      end
    end
    ok = cv && !bad && tot <= 32;
    @(negedge clk);
    cfg_valid = cv; setvl_valid = sv; setvl_req = req;
    for (int g = 0; g < 4; g++) begin
      cfg_cnt[g*6 +: 6] = 6'(cnt[g]);
      cfg_type[g*5 +: 5] = ty[g];
    end
    @(negedge clk);
    cfg_valid = 0; setvl_valid = 0;
    if (ok) begin
      int b = 0;
      m_n = tot; m_maxvl = exp_maxvl(s); m_vl = 0; exp_rd = 0;
      for (int i = 0; i < 32; i++) m_type[i] = 0;
      for (int g = 0; g < 4; g++)
        for (int k = 0; k < cnt[g]; k++) begin m_type[b] = ty[g]; b++; end
    end else if (sv) begin
      m_vl = (req > m_maxvl) ? m_maxvl : req;
      exp_rd = m_vl;
    end
    chk(cfg_err === (cv && !ok), {tag, " R5 err"}, int'(cfg_err), int'(cv && !ok));
    chk(maxvl === 11'(m_maxvl), {tag, " R4 maxvl"}, int'(maxvl), m_maxvl);
    chk(vl === 11'(m_vl), {tag, " R7/R8 vl"}, int'(vl), m_vl);
    if (sv) chk(rd_valid === 1'b1 && rd_data === 32'(exp_rd), {tag, " R7 rd_data"}, int'(rd_data), exp_rd);
    if (ok) begin
      for (int k = 0; k < tot; k++) begin
        if (zero_valid !== 1'b1 || zero_idx !== 5'(k)) nz++;
        @(negedge clk);
      end
      chk(nz == 0, {tag, " R6 zero sequence"}, nz, 0);
    end
    chk(zero_valid === 1'b0, {tag, " R6 zero idle"}, int'(zero_valid), 0);
    check_access(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int c[4];
    logic [4:0] t[4];
    void'($urandom(32'd4177));
    for (int i = 0; i < 32; i++) m_type[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(maxvl === 0 && vl === 0, "R1 reset lengths", int'(maxvl), 0);
    chk(zero_valid === 1'b0, "R1 reset zero", int'(zero_valid), 0);
    check_access("R1 reset");

    c = '{3, 0, 0, 0}; t = '{5'b00_010, 0, 0, 0};
    do_cmd(1, c, t, 0, 0, "R4 three int32");
    c = '{0, 0, 0, 0};
    do_cmd(0, c, t, 1, 100, "R7 clamp high");
    do_cmd(0, c, t, 1, 10, "R7 under max");
    c = '{2, 1, 4, 1}; t = '{5'b01_000, 5'b10_011, 5'b00_001, 5'b10_100};
    do_cmd(1, c, t, 0, 0, "R2 four groups");
    c = '{20, 13, 0, 0}; t = '{5'b00_000, 5'b00_000, 0, 0};
    do_cmd(1, c, t, 1, 3, "R5 R9 overflow plus setvl");
    c = '{2, 0, 0, 0}; t = '{5'b11_000, 0, 0, 0};
    do_cmd(1, c, t, 0, 0, "R5 bad repr");
    c = '{2, 0, 0, 0}; t = '{5'b00_101, 0, 0, 0};
    do_cmd(1, c, t, 1, 7, "R5 R9 bad width plus setvl");
    c = '{1, 0, 2, 0}; t = '{5'b00_000, 5'b11_111, 5'b01_001, 5'b11_110};
    do_cmd(1, c, t, 0, 0, "R10 zero-count bad type");
    c = '{32, 0, 0, 0}; t = '{5'b10_100, 0, 0, 0};
    do_cmd(1, c, t, 1, 500, "R8 full 128b with setvl");
    do_cmd(0, '{0, 0, 0, 0}, t, 1, 500, "R4 full 128b grant");
    c = '{32, 0, 0, 0}; t = '{5'b01_000, 0, 0, 0};
    do_cmd(1, c, t, 1, 9999, "R4 full 8b");
    do_cmd(0, '{0, 0, 0, 0}, t, 1, 9999, "R7 full 8b grant");
    c = '{1, 0, 0, 0};
    do_cmd(1, c, t, 0, 0, "R4 single 8b");
    do_cmd(0, '{0, 0, 0, 0}, t, 1, 2000, "R7 single 8b grant");
    do_cmd(0, '{0, 0, 0, 0}, t, 1, 0, "R7 zero request");
    do_cmd(1, '{0, 0, 0, 0}, t, 1, 5, "R4 R6 empty config");

    for (int it = 0; it < 80; it++) begin
      for (int g = 0; g < 4; g++) begin
        c[g] = $urandom_range(0, 11);
        t[g] = {2'($urandom_range(0, 2)), 3'($urandom_range(0, 4))};
        if ($urandom_range(0, 9) == 0) t[g] = 5'($urandom);
      end
      do_cmd($urandom_range(0, 1), c, t, $urandom_range(0, 1), $urandom_range(0, 1200), "random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule